// File: doc/BRIEF.md
# Drum Timing Clock Generator

This block turns the recovered bit clock of a rotating drum store into the timing strobes that a drum controller uses. Two prerecorded bit-clock tracks arrive as synchronized levels in a faster system clock domain. A static select input picks one of them. The choice is taken only while no read, write or test operation is in progress, so the clock never changes in the middle of a transfer.

Each rising edge of the selected track becomes a one-cycle bit enable. Bits are counted into 32-bit words and words into revolutions of 1249 words. From these counters the block produces four outputs:

- a byte clock, four times per word;
- a word clock, once per word;
- a tachometer pulse, once per revolution;
- the current word index.

The selected track level is also copied to a test output, and a test-inhibit input forces that output low.

All outputs are registered. The block uses no gated clocks: bit timing is carried only as enables in the system clock domain.

Top module: `drum_timing_gen`

## Requirements
- R1: While reset is held, and after it releases until the first selected rising edge, bit_clk_tst, byte_clk, word_clk and tach_pulse are 0 and word_index is 0.
- R2: The active track is trk_a_lvl when the stored select is 0 and trk_b_lvl when it is 1. The stored select takes trk_sel on each clock where busy is 0, and it holds its value while busy is 1.
- R3: bit_clk_tst equals the active track level sampled at the previous clock edge, ANDed with the inverse of test_inhibit at that same edge. A test_inhibit of 1 therefore gives 0 on the next cycle.
- R4: A bit is counted once for each clock where the active track is sampled high after being sampled low on the previous clock.
- R5: byte_clk is a one-cycle pulse for the bits at positions 0, 8, 16 and 24 of each 32-bit word, where position 0 is the first bit after reset or after a word wraps. This gives four byte pulses per word.
- R6: word_clk is a one-cycle pulse for bit position 0 of every word. word_index counts words from 0 to 1248, advances after bit position 31, and wraps to 0.
- R7: tach_pulse is a one-cycle pulse for bit position 0 of word 0. It appears exactly once in every 39968 counted bits, and always together with word_clk.
- R8: Edges on the track that is not active change no output and no counter.
- R9: Every strobe output rises on the clock edge that follows the first edge at which the counted rising level is sampled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, faster than twice the bit rate |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| trk_a_lvl | input | 1 | Synchronized level of bit-clock track A |
| trk_b_lvl | input | 1 | Synchronized level of bit-clock track B |
| trk_sel | input | 1 | Track select switch: 0 picks A, 1 picks B |
| busy | input | 1 | High during a read, write or test operation; freezes the selection |
| test_inhibit | input | 1 | High forces bit_clk_tst low |
| bit_clk_tst | output | 1 | Gated copy of the active bit clock |
| byte_clk | output | 1 | One-cycle pulse per byte |
| word_clk | output | 1 | One-cycle pulse per word |
| tach_pulse | output | 1 | One-cycle pulse per revolution |
| word_index | output | 11 | Current word number within the revolution |

## Verification
The assertions check several relations on every cycle:

- that the inhibited test output is low;
- that the selection holds while busy;
- that a tachometer pulse always comes with a word pulse, and a word pulse always with a byte pulse;
- that byte pulses never last two cycles;
- that the word index stays below 1249.

Three properties need the bench's scenarios. One is the byte positions within a word. Another is that unselected track edges are ignored. The last is the exact count of 1249 words and 4996 bytes within one revolution of 39968 bits. The bench checks these against a cycle model and with a directed full-revolution run.

// File: rtl/drum_timing_pkg.sv
package drum_timing_pkg;
  localparam int unsigned DEF_BITS_PER_WORD = 32;
  localparam int unsigned DEF_BITS_PER_BYTE = 8;
  localparam int unsigned DEF_WORDS_PER_REV = 1249;

  typedef enum logic {
    TRK_A = 1'b0,
    TRK_B = 1'b1
  } trk_id_e;
endpackage

// File: rtl/drum_trk_select.sv
module drum_trk_select
  import drum_timing_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic trk_a_lvl,
  input  logic trk_b_lvl,
  input  logic sel_in,
  input  logic busy,
  input  logic test_inhibit,
  output logic bit_stb,
  output logic tst_out
);
  trk_id_e sel_q, sel_d;
  logic    prev_q, prev_d;
  logic    tst_q, tst_d;
  logic    lvl;

  always_comb begin
    lvl     = (sel_q == TRK_B) ? trk_b_lvl : trk_a_lvl;
    bit_stb = lvl & ~prev_q;
    prev_d  = lvl;
    tst_d   = lvl & ~test_inhibit;
    sel_d   = sel_q;
    if (!busy) sel_d = trk_id_e'(sel_in);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_q  <= TRK_A;
      prev_q <= 1'b0;
      tst_q  <= 1'b0;
    end else begin
      sel_q  <= sel_d;
      prev_q <= prev_d;
      tst_q  <= tst_d;
    end
  end

  assign tst_out = tst_q;
endmodule

// File: rtl/drum_bit_counter.sv
module drum_bit_counter #(
  parameter int unsigned BITS_PER_WORD = drum_timing_pkg::DEF_BITS_PER_WORD,
  parameter int unsigned BITS_PER_BYTE = drum_timing_pkg::DEF_BITS_PER_BYTE
) (
  input  logic clk,
  input  logic rst_n,
  input  logic bit_stb,
  output logic byte_stb,
  output logic word_start,
  output logic word_end
);
  localparam int unsigned CW = $clog2(BITS_PER_WORD);
  localparam logic [CW-1:0] LAST_BIT  = CW'(BITS_PER_WORD - 1);
  localparam logic [CW-1:0] BYTE_MASK = CW'(BITS_PER_BYTE - 1);

  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    byte_stb   = bit_stb && ((cnt_q & BYTE_MASK) == '0);
    word_start = bit_stb && (cnt_q == '0);
    word_end   = bit_stb && (cnt_q == LAST_BIT);
    cnt_d      = cnt_q;
    if (bit_stb) cnt_d = (cnt_q == LAST_BIT) ? '0 : cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end
endmodule

// File: rtl/drum_word_counter.sv
module drum_word_counter #(
  parameter int unsigned WORDS_PER_REV = drum_timing_pkg::DEF_WORDS_PER_REV,
  parameter int unsigned WW            = $clog2(WORDS_PER_REV)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          word_start,
  input  logic          word_end,
  output logic          rev_stb,
  output logic [WW-1:0] word_cnt
);
  localparam logic [WW-1:0] LAST_WORD = WW'(WORDS_PER_REV - 1);

  logic [WW-1:0] wcnt_q, wcnt_d;

  always_comb begin
    rev_stb = word_start && (wcnt_q == '0);
    wcnt_d  = wcnt_q;
    if (word_end) wcnt_d = (wcnt_q == LAST_WORD) ? '0 : wcnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) wcnt_q <= '0;
    else        wcnt_q <= wcnt_d;
  end

  assign word_cnt = wcnt_q;
endmodule

// File: rtl/drum_timing_gen.sv
module drum_timing_gen #(
  parameter int unsigned BITS_PER_WORD = drum_timing_pkg::DEF_BITS_PER_WORD,
  parameter int unsigned BITS_PER_BYTE = drum_timing_pkg::DEF_BITS_PER_BYTE,
  parameter int unsigned WORDS_PER_REV = drum_timing_pkg::DEF_WORDS_PER_REV,
  parameter int unsigned WW            = $clog2(WORDS_PER_REV)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          trk_a_lvl,
  input  logic          trk_b_lvl,
  input  logic          trk_sel,
  input  logic          busy,
  input  logic          test_inhibit,
  output logic          bit_clk_tst,
  output logic          byte_clk,
  output logic          word_clk,
  output logic          tach_pulse,
  output logic [WW-1:0] word_index
);
  logic [1:0] rst_sync_q;
  logic       rst_int_n;
  logic       bit_stb, byte_stb, word_start, word_end, rev_stb;
  logic       byte_q, word_q, tach_q;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  drum_trk_select u_sel (
    .clk          (clk),
    .rst_n        (rst_int_n),
    .trk_a_lvl    (trk_a_lvl),
    .trk_b_lvl    (trk_b_lvl),
    .sel_in       (trk_sel),
    .busy         (busy),
    .test_inhibit (test_inhibit),
    .bit_stb      (bit_stb),
    .tst_out      (bit_clk_tst)
  );

  drum_bit_counter #(
    .BITS_PER_WORD (BITS_PER_WORD),
    .BITS_PER_BYTE (BITS_PER_BYTE)
  ) u_bits (
    .clk        (clk),
    .rst_n      (rst_int_n),
    .bit_stb    (bit_stb),
    .byte_stb   (byte_stb),
    .word_start (word_start),
    .word_end   (word_end)
  );

  drum_word_counter #(
    .WORDS_PER_REV (WORDS_PER_REV),
    .WW            (WW)
  ) u_words (
    .clk        (clk),
    .rst_n      (rst_int_n),
    .word_start (word_start),
    .word_end   (word_end),
    .rev_stb    (rev_stb),
    .word_cnt   (word_index)
  );

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      byte_q <= 1'b0;
      word_q <= 1'b0;
      tach_q <= 1'b0;
    end else begin
      byte_q <= byte_stb;
      word_q <= word_start;
      tach_q <= rev_stb;
    end
  end

  assign byte_clk   = byte_q;
  assign word_clk   = word_q;
  assign tach_pulse = tach_q;
endmodule

// File: rtl/drum_timing_gen_chk.sv
module drum_timing_gen_chk #(
  parameter int unsigned WORDS_PER_REV = drum_timing_pkg::DEF_WORDS_PER_REV,
  parameter int unsigned WW            = $clog2(WORDS_PER_REV)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          busy,
  input logic          test_inhibit,
  input logic          sel_cur,
  input logic          bit_clk_tst,
  input logic          byte_clk,
  input logic          word_clk,
  input logic          tach_pulse,
  input logic [WW-1:0] word_index
);
  // R3
  inhibit_blocks_tst_chk: assert property (@(posedge clk) disable iff (!rst_n)
    test_inhibit |=> !bit_clk_tst);

  // R2
  sel_held_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> $stable(sel_cur));

  // R7
  tach_with_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tach_pulse |-> word_clk);

  // R6
  word_with_byte_chk: assert property (@(posedge clk) disable iff (!rst_n)
    word_clk |-> byte_clk);

  // R5
  byte_single_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    byte_clk |=> !byte_clk);

  // R6
  word_index_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    word_index < WW'(WORDS_PER_REV));
endmodule

bind drum_timing_gen drum_timing_gen_chk #(
  .WORDS_PER_REV (WORDS_PER_REV),
  .WW            (WW)
) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .busy         (busy),
  .test_inhibit (test_inhibit),
  .sel_cur      (u_sel.sel_q),
  .bit_clk_tst  (bit_clk_tst),
  .byte_clk     (byte_clk),
  .word_clk     (word_clk),
  .tach_pulse   (tach_pulse),
  .word_index   (word_index)
);

// File: tb/drum_timing_gen_tb.sv
`timescale 1ns/1ps
module drum_timing_gen_tb;
  localparam int BPW = 32;
  localparam int WPR = 1249;

  logic clk = 1'b0;
  logic rst_n;
  logic ta, tb, tsel, busy, inh;
  logic bit_clk_tst, byte_clk, word_clk, tach_pulse;
  logic [10:0] word_index;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;
  bit model_on = 1'b0;

  // reference model state
  bit sel_m, prev_m;
  int bit_m, word_m;
  bit e_tst, e_byte, e_word, e_tach;
  int n_byte, n_word, n_tach;

  always #4 clk = ~clk;

  drum_timing_gen u_dut (
    .clk(clk), .rst_n(rst_n), .trk_a_lvl(ta), .trk_b_lvl(tb),
    .trk_sel(tsel), .busy(busy), .test_inhibit(inh),
    .bit_clk_tst(bit_clk_tst), .byte_clk(byte_clk), .word_clk(word_clk),
    .tach_pulse(tach_pulse), .word_index(word_index)
  );

  function automatic bit on_byte_pos(int pos);
    return (pos % 8) == 0;
  endfunction

  function automatic int next_word(int w);
    return (w == WPR - 1) ? 0 : w + 1;
  endfunction

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s got %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  // cycle model; R4 edge rule, R8 only the active track counts
  always @(posedge clk) begin
    if (model_on) begin
      bit lvl, stb;
      lvl    = sel_m ? tb : ta;
      stb    = lvl & ~prev_m;
      e_tst  = lvl & ~inh;
      e_byte = stb && on_byte_pos(bit_m);
      e_word = stb && (bit_m == 0);
      e_tach = e_word && (word_m == 0);
      if (stb) begin
        if (bit_m == BPW - 1) begin
          bit_m  = 0;
          word_m = next_word(word_m);
        end else begin
          bit_m++;
        end
      end
      prev_m = lvl;
      if (!busy) sel_m = tsel;
    end
  end

  // compare away from the active edge; R9 latency is built into the model
  always @(negedge clk) begin
    if (model_on) begin
      chk("R3 bit_clk_tst", bit_clk_tst, e_tst);
      chk("R5 byte_clk (R4,R9)", byte_clk, e_byte);
      chk("R6 word_clk", word_clk, e_word);
      chk("R7 tach_pulse", tach_pulse, e_tach);
      chk("R6 word_index", word_index, word_m);
      n_byte += byte_clk;
      n_word += word_clk;
      n_tach += tach_pulse;
    end
  end

  task automatic step(bit a, bit b);
    @(negedge clk);
    ta = a;
    tb = b;
  endtask

  task automatic report;
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  initial begin
    #(190000 * 8);
    fails++;
    $display("FAIL watchdog expired");
    report();
  end

  initial begin
    int s0, s1, s2;
    void'($urandom(32'd4711));
    rst_n = 1'b0; ta = 0; tb = 0; tsel = 0; busy = 0; inh = 0;
    repeat (5) @(negedge clk);
    // R1 during reset
    chk("R1 byte_clk", byte_clk, 0);
    chk("R1 word_clk", word_clk, 0);
    chk("R1 tach_pulse", tach_pulse, 0);
    chk("R1 bit_clk_tst", bit_clk_tst, 0);
    chk("R1 word_index", word_index, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R1 tach_pulse after release", tach_pulse, 0);
    sel_m = 0; prev_m = 0; bit_m = 0; word_m = 0;
    model_on = 1'b1;

    // R5/R6: both tracks, track A active, 40 bits
    for (int i = 0; i < 40; i++) begin step(1, 1); step(0, 0); end

    // R8: only the inactive track B moves
    s0 = n_byte;
    for (int i = 0; i < 20; i++) begin step(0, 1); step(0, 0); end
    chk("R8 no bytes from inactive track", n_byte - s0, 0);

    // R2: busy holds A even though the switch says B
    busy = 1; tsel = 1;
    s0 = n_byte;
    for (int i = 0; i < 24; i++) begin step(0, 1); step(0, 0); end
    chk("R2 selection held while busy", n_byte - s0, 0);
    busy = 0;
    step(0, 0);
    busy = 1;
    // R2: now B active; 32 bits give exactly 4 bytes
    s0 = n_byte;
    for (int i = 0; i < 32; i++) begin step(0, 1); step(0, 0); end
    chk("R2 track B counts after idle", n_byte - s0, 4);

    // R3 directed: inhibit while B high
    inh = 1; step(0, 1); step(0, 1);
    chk("R3 inhibited output", bit_clk_tst, 0);
    inh = 0; step(0, 1);
    chk("R3 passes when released", bit_clk_tst, 1);
    step(0, 0);

    // random mix
    for (int i = 0; i < 3000; i++) begin
      busy = ($urandom % 8) != 0;
      tsel = $urandom;
      inh  = ($urandom % 4) == 0;
      step($urandom, $urandom);
    end

    // full revolution: fixed selection, one bit every two cycles
    busy = 1; inh = 0;
    step(0, 0);
    s0 = n_byte; s1 = n_word; s2 = n_tach;
    for (int i = 0; i < BPW * WPR; i++) begin step(1, 1); step(0, 0); end
    step(0, 0);
    chk("R7 one tach per 39968 bits", n_tach - s2, 1);
    chk("R6 words per revolution", n_word - s1, WPR);
    chk("R5 bytes per revolution", n_byte - s0, 4 * WPR);
    report();
  end
endmodule